// File: doc/BRIEF.md
# Host Schedule Command and Status Register Block

This block holds the software-visible controls that steer a USB-style host scheduler. These are the enables for the asynchronous and periodic schedules, the asynchronous park count with its park-mode enable, a 3-bit frame-list size code and the async-advance doorbell. Software reaches it through a 32-bit word-addressed register port. Writes take effect on the clock edge at which `reg_wr` is high. Reads are combinational from `reg_addr`. The port has no handshake because every access completes in one cycle.

The scheduler core sees the schedule enables, the park settings and the doorbell as plain level outputs. It answers a rung doorbell with a one-cycle `evict_done_i` pulse once it has dropped its cached schedule state. The block then raises the advance status flag and retires the doorbell one cycle later. The interrupt is not raised right away. It is held back until the next interrupt-threshold tick.

A free-running frame counter comes in on `frame_cnt_i`. Its three low bits count microframes. The block masks the bits above them down to the selected list length, which gives the current frame-list index.

Top module: `hsc_sched_cmd`

Register map (word address on `reg_addr`):
- 0, command: [0] async enable, [1] periodic enable, [3:2] size code low bits, [4] doorbell, [5] light reset (always 0), [7:6] park count, [8] park-mode enable, [15] size code high bit.
- 1, status (write 1 to clear): [0] advance flag, [1] park error, [2] doorbell error.
- 2, interrupt enable: [0] advance interrupt enable.
- 3 and all unlisted bits read 0.

## Requirements
- R1: After reset the command register reads 32'h000000C0 (park count 3, everything else 0), status and interrupt enable read 0, and `doorbell_o`, `irq_o` are 0.
- R2: Command bits [0] and [1] drive `async_en_o` and `periodic_en_o` from the edge of the write onward and read back unchanged.
- R3: A command write carrying park-mode enable (bit 8) = 1 with park count (bits 7:6) = 0 leaves both park fields unchanged and sets status bit 1. Every other command write stores both park fields, with the other fields of the same write still taking effect.
- R4: Writing 1 to command bit 4 while async enable currently reads 1 sets the doorbell. Writing 0 to that bit never clears it.
- R5: An `evict_done_i` pulse while the doorbell is set raises status bit 0 at that edge. The doorbell clears at the following edge. A pulse while the doorbell is clear changes nothing.
- R6: Status bits are cleared only by writing 1 to them. Writing 0 leaves them set.
- R7: `irq_o` rises only at an edge where `thresh_tick_i` is high while status bit 0 and interrupt-enable bit 0 are both set. It falls at the edge where either of them is cleared.
- R8: Writing 1 to command bit 4 while async enable reads 0 leaves the doorbell clear and sets status bit 2.
- R9: The size code is {bit 15, bits 3:2}. Codes 0 to 7 select 1024, 512, 256, 128, 64, 32, 16 and 8 entries. With `PROG_FRAME_LIST` = 0 the code stays 0 and writes to it are ignored.
- R10: Command bit 5 always reads 0, whatever was written.
- R11: `frame_idx_o` equals `frame_cnt_i[N+2:3]` zero-extended to 10 bits, where 2^N is the selected entry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evict_done_i | input | 1 | Scheduler has dropped cached schedule state |
| thresh_tick_i | input | 1 | Interrupt-threshold tick |
| frame_cnt_i | input | FCNT_W | Free-running frame/microframe counter |
| async_en_o | output | 1 | Process the asynchronous schedule |
| periodic_en_o | output | 1 | Process the periodic schedule |
| park_en_o | output | 1 | Async park mode enabled |
| park_cnt_o | output | 2 | Async park count |
| doorbell_o | output | 1 | Async-advance doorbell pending |
| irq_o | output | 1 | Async-advance interrupt |
| frame_idx_o | output | 10 | Frame-list current index |

## Verification
The doorbell handshake is run with the eviction pulse delayed several cycles and with threshold ticks held off, so that an immediate interrupt and an early doorbell clear stand out from the required behaviour. Eviction pulses with no doorbell pending, doorbell rings with the async schedule off, and zero park counts written with and without park mode each probe one rejection path on its own. The index is checked for all eight size codes against an all-ones counter and a mixed-bit counter. The all-ones value exposes a wrong mask width, and the mixed value exposes a wrong bit offset. A second instance built without the programmable size confirms that size writes are ignored there.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam int unsigned IDX_W = 10;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_IEN  = 2'd2;

  localparam int unsigned CMD_ASYNC    = 0;
  localparam int unsigned CMD_PERIODIC = 1;
  localparam int unsigned CMD_SIZE_LO  = 2;
  localparam int unsigned CMD_DOORBELL = 4;
  localparam int unsigned CMD_PARK_LO  = 6;
  localparam int unsigned CMD_PARK_EN  = 8;
  localparam int unsigned CMD_SIZE_HI  = 15;

  localparam int unsigned ST_ADV    = 0;
  localparam int unsigned ST_PARKER = 1;
  localparam int unsigned ST_DBERR  = 2;

  localparam logic [1:0] PARK_RESET = 2'd3;

  typedef struct packed {
    logic       async_en;
    logic       periodic_en;
    logic       park_en;
    logic [1:0] park_cnt;
    logic [2:0] size_code;
    logic       doorbell;
  } cmd_fields_t;
endpackage

// File: rtl/hsc_cmd_regs.sv
module hsc_cmd_regs
  import hsc_pkg::*;
#(
  parameter bit PROG_FRAME_LIST = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic [31:0] wdata,
  input  logic        db_clear,
  output cmd_fields_t fields,
  output logic        db_err_set,
  output logic        park_err_set
);
  logic async_en, periodic_en, park_en, doorbell;
  logic [1:0] park_cnt;
  logic [2:0] size_code;
  logic park_bad, db_ring;

  always_comb begin
    park_bad     = wr_cmd && wdata[CMD_PARK_EN] && (wdata[CMD_PARK_LO +: 2] == 2'd0);
    db_ring      = wr_cmd && wdata[CMD_DOORBELL];
    db_err_set   = db_ring && !async_en;
    park_err_set = park_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      async_en    <= 1'b0;
      periodic_en <= 1'b0;
      park_en     <= 1'b0;
      park_cnt    <= PARK_RESET;
    end else if (wr_cmd) begin
      async_en    <= wdata[CMD_ASYNC];
      periodic_en <= wdata[CMD_PERIODIC];
      if (!park_bad) begin
        park_en  <= wdata[CMD_PARK_EN];
        park_cnt <= wdata[CMD_PARK_LO +: 2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   doorbell <= 1'b0;
    else if (db_ring && async_en) doorbell <= 1'b1;
    else if (db_clear)            doorbell <= 1'b0;
  end

  generate
    if (PROG_FRAME_LIST) begin : g_size_rw
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      size_code <= 3'd0;
        else if (wr_cmd) size_code <= {wdata[CMD_SIZE_HI], wdata[CMD_SIZE_LO +: 2]};
      end
    end else begin : g_size_fixed
      assign size_code = 3'd0;
    end
  endgenerate

  assign fields = '{async_en: async_en, periodic_en: periodic_en, park_en: park_en,
                    park_cnt: park_cnt, size_code: size_code, doorbell: doorbell};

  a_r3_park_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    park_en |-> (park_cnt != 2'd0));
  a_r4_db_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doorbell) |-> $past(wr_cmd && wdata[CMD_DOORBELL] && async_en));
  a_r5_db_clear_by_hw: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doorbell) |-> $past(db_clear));
endmodule

// File: rtl/hsc_adv_ctrl.sv
module hsc_adv_ctrl
  import hsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stat,
  input  logic       wr_ien,
  input  logic [2:0] wdata,
  input  logic       doorbell,
  input  logic       evict_done,
  input  logic       tick,
  input  logic       db_err_set,
  input  logic       park_err_set,
  output logic [2:0] status,
  output logic       ien,
  output logic       irq,
  output logic       db_clear
);
  logic [2:0] status_nx, w1c, set_v;
  logic ien_nx, flag_set;

  always_comb begin
    flag_set  = doorbell && evict_done;
    set_v     = '0;
    set_v[ST_ADV]    = flag_set;
    set_v[ST_PARKER] = park_err_set;
    set_v[ST_DBERR]  = db_err_set;
    w1c       = wr_stat ? wdata : 3'b000;
    status_nx = set_v | (status & ~w1c);
    ien_nx    = wr_ien ? wdata[0] : ien;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      ien      <= 1'b0;
      irq      <= 1'b0;
      db_clear <= 1'b0;
    end else begin
      status   <= status_nx;
      ien      <= ien_nx;
      db_clear <= flag_set;
      if (!(status_nx[ST_ADV] && ien_nx)) irq <= 1'b0;
      else if (tick)                      irq <= 1'b1;
    end
  end

  a_r5_clear_after_flag: assert property (@(posedge clk) disable iff (!rst_n)
    db_clear |-> status[ST_ADV]);
  a_r7_irq_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));
  a_r7_irq_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status[ST_ADV] && ien));
  a_r6_flag_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[ST_ADV]) |-> $past(wr_stat && wdata[ST_ADV]));
endmodule

// File: rtl/hsc_frame_index.sv
module hsc_frame_index
  import hsc_pkg::*;
#(
  parameter int unsigned FCNT_W = 13
) (
  input  logic [FCNT_W-1:0] frame_cnt,
  input  logic [2:0]        size_code,
  output logic [IDX_W-1:0]  frame_idx
);
  localparam int unsigned UF_BITS = 3;
  logic [IDX_W-1:0] mask;
  logic [UF_BITS-1:0] unused_uframe;

  always_comb begin
    mask          = {IDX_W{1'b1}} >> size_code;
    frame_idx     = frame_cnt[UF_BITS +: IDX_W] & mask;
    unused_uframe = frame_cnt[UF_BITS-1:0];
  end

  always_comb begin
    a_r11_idx_in_range: assert ((frame_idx >> (IDX_W - int'(size_code))) == '0);
  end
endmodule

// File: rtl/hsc_sched_cmd.sv
module hsc_sched_cmd
  import hsc_pkg::*;
#(
  parameter bit          PROG_FRAME_LIST = 1'b1,
  parameter int unsigned FCNT_W          = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              evict_done_i,
  input  logic              thresh_tick_i,
  input  logic [FCNT_W-1:0] frame_cnt_i,
  output logic              async_en_o,
  output logic              periodic_en_o,
  output logic              park_en_o,
  output logic [1:0]        park_cnt_o,
  output logic              doorbell_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  frame_idx_o
);
  cmd_fields_t f;
  logic wr_cmd, wr_stat, wr_ien, db_clear, db_err_set, park_err_set, ien;
  logic [2:0] status;
  logic [31:0] cmd_word;

  assign wr_cmd  = reg_wr && (reg_addr == ADDR_CMD);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_ien  = reg_wr && (reg_addr == ADDR_IEN);

  hsc_cmd_regs #(.PROG_FRAME_LIST(PROG_FRAME_LIST)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(reg_wdata),
    .db_clear(db_clear), .fields(f),
    .db_err_set(db_err_set), .park_err_set(park_err_set));

  hsc_adv_ctrl u_adv (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .wr_ien(wr_ien),
    .wdata(reg_wdata[2:0]), .doorbell(f.doorbell), .evict_done(evict_done_i),
    .tick(thresh_tick_i), .db_err_set(db_err_set), .park_err_set(park_err_set),
    .status(status), .ien(ien), .irq(irq_o), .db_clear(db_clear));

  hsc_frame_index #(.FCNT_W(FCNT_W)) u_idx (
    .frame_cnt(frame_cnt_i), .size_code(f.size_code), .frame_idx(frame_idx_o));

  always_comb begin
    cmd_word = '0;
    cmd_word[CMD_ASYNC]          = f.async_en;
    cmd_word[CMD_PERIODIC]       = f.periodic_en;
    cmd_word[CMD_SIZE_LO +: 2]   = f.size_code[1:0];
    cmd_word[CMD_DOORBELL]       = f.doorbell;
    cmd_word[CMD_PARK_LO +: 2]   = f.park_cnt;
    cmd_word[CMD_PARK_EN]        = f.park_en;
    cmd_word[CMD_SIZE_HI]        = f.size_code[2];
    unique case (reg_addr)
      ADDR_CMD:  reg_rdata = cmd_word;
      ADDR_STAT: reg_rdata = {29'd0, status};
      ADDR_IEN:  reg_rdata = {31'd0, ien};
      default:   reg_rdata = '0;
    endcase
  end

  assign async_en_o    = f.async_en;
  assign periodic_en_o = f.periodic_en;
  assign park_en_o     = f.park_en;
  assign park_cnt_o    = f.park_cnt;
  assign doorbell_o    = f.doorbell;

  a_r10_light_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_CMD) |-> (reg_rdata[5] == 1'b0));
endmodule

// File: tb/hsc_sched_cmd_bench.sv
module hsc_sched_cmd_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic evict = 1'b0, tick = 1'b0;
  logic [12:0] fcnt = '0;
  logic [31:0] rdata, x_rdata;
  logic async_en, periodic_en, park_en, doorbell, irq;
  logic x_async_en, x_periodic_en, x_park_en, x_doorbell, x_irq;
  logic [1:0] park_cnt, x_park_cnt;
  logic [9:0] idx, x_idx;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hsc_sched_cmd u_hsc_sched_cmd (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .evict_done_i(evict),
    .thresh_tick_i(tick), .frame_cnt_i(fcnt), .async_en_o(async_en),
    .periodic_en_o(periodic_en), .park_en_o(park_en), .park_cnt_o(park_cnt),
    .doorbell_o(doorbell), .irq_o(irq), .frame_idx_o(idx));

  hsc_sched_cmd #(.PROG_FRAME_LIST(1'b0)) u_hsc_sched_cmd_fixed (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(x_rdata), .evict_done_i(evict),
    .thresh_tick_i(tick), .frame_cnt_i(fcnt), .async_en_o(x_async_en),
    .periodic_en_o(x_periodic_en), .park_en_o(x_park_en), .park_cnt_o(x_park_cnt),
    .doorbell_o(x_doorbell), .irq_o(x_irq), .frame_idx_o(x_idx));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = rdata;
  endtask

  task automatic pulse_evict();
    @(negedge clk); evict = 1'b1;
    @(negedge clk); evict = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk("R1 cmd", d, 32'h0000_00C0);
    rd(2'd1, d); chk("R1 stat", d, 32'h0);
    rd(2'd2, d); chk("R1 ien", d, 32'h0);
    chk("R1 outs", {doorbell, irq, async_en, park_cnt}, {3'b000, 2'd3});
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(2'd0, 32'h0000_00C3);
    chk("R2 outs", {async_en, periodic_en}, 2'b11);
    rd(2'd0, d); chk("R2 readback", d, 32'h0000_00C3);
    wr(2'd0, 32'h0000_00C2);
    chk("R2 async off", {async_en, periodic_en}, 2'b01);
    wr(2'd0, 32'h0000_00C3);
  endtask

  task automatic t_park();
    logic [31:0] d;
    wr(2'd0, 32'h0000_0183);
    chk("R3 park set", {park_en, park_cnt}, {1'b1, 2'd2});
    wr(2'd0, 32'h0000_0103);
    rd(2'd0, d); chk("R3 zero rejected", d, 32'h0000_0183);
    rd(2'd1, d); chk("R3 park err", d, 32'h2);
    wr(2'd1, 32'h2);
    rd(2'd1, d); chk("R6 w1c park err", d, 32'h0);
    wr(2'd0, 32'h0000_0003);
    chk("R3 zero ok without park", {park_en, park_cnt}, 3'b000);
    rd(2'd1, d); chk("R3 no err", d, 32'h0);
    wr(2'd0, 32'h0000_00C3);
  endtask

  task automatic t_light_reset();
    logic [31:0] d;
    wr(2'd0, 32'h0000_00E3);
    rd(2'd0, d); chk("R10 bit5 zero", d, 32'h0000_00C3);
  endtask

  task automatic t_doorbell();
    logic [31:0] d;
    pulse_evict();
    rd(2'd1, d); chk("R5 evict without doorbell", d, 32'h0);
    wr(2'd0, 32'h0000_00D3);
    chk("R4 ring", doorbell, 1'b1);
    wr(2'd0, 32'h0000_00C3);
    chk("R4 write 0 no effect", doorbell, 1'b1);
    repeat (4) @(negedge clk);
    chk("R5 waits for eviction", doorbell, 1'b1);
    @(negedge clk); evict = 1'b1;
    @(negedge clk); evict = 1'b0;
    rd(2'd1, d); chk("R5 flag set", d, 32'h1);
    chk("R5 doorbell held one cycle", doorbell, 1'b1);
    @(negedge clk);
    chk("R5 doorbell cleared", doorbell, 1'b0);
    chk("R7 no irq when disabled", irq, 1'b0);
    wr(2'd1, 32'h0);
    rd(2'd1, d); chk("R6 write 0 keeps", d, 32'h1);
    wr(2'd1, 32'h1);
    rd(2'd1, d); chk("R6 write 1 clears", d, 32'h0);
  endtask

  task automatic t_irq();
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h0000_00D3);
    repeat (3) @(negedge clk);
    pulse_evict();
    chk("R7 no irq before tick", irq, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 still waiting", irq, 1'b0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R7 irq at tick", irq, 1'b1);
    wr(2'd1, 32'h1);
    chk("R7 irq drops on clear", irq, 1'b0);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_db_disabled();
    logic [31:0] d;
    wr(2'd0, 32'h0000_00C0);
    wr(2'd0, 32'h0000_00D0);
    chk("R8 doorbell ignored", doorbell, 1'b0);
    rd(2'd1, d); chk("R8 err flag", d, 32'h4);
    rd(2'd0, d); chk("R8 cmd", d, 32'h0000_00C0);
    wr(2'd1, 32'h4);
  endtask

  task automatic t_size();
    logic [31:0] d, w;
    for (int c = 0; c < 8; c++) begin
      w = 32'h0000_00C3 | (32'(c >> 2) << 15) | (32'(c & 3) << 2);
      wr(2'd0, w);
      rd(2'd0, d); chk("R9 size readback", d, w);
      chk("R9 fixed ignores size", x_rdata, w & ~32'h0000_800C);
      fcnt = 13'h1FFF; #1;
      chk("R11 idx all ones", {22'd0, idx}, (32'h1FFF >> 3) & ((32'd1 << (10 - c)) - 1));
      fcnt = 13'h0B5D; #1;
      chk("R11 idx mixed", {22'd0, idx}, (32'h0B5D >> 3) & ((32'd1 << (10 - c)) - 1));
      chk("R9 fixed idx full", {22'd0, x_idx}, 32'h0B5D >> 3);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_park();
    t_light_reset();
    t_doorbell();
    t_irq();
    t_db_disabled();
    t_size();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end
endmodule